// File: doc/BRIEF.md
# Three-Wire Serial Register Interface

This block is the peripheral end of a three-wire host bus. The bus has a read/write select, a serial clock and a single bidirectional data line. When the select is high the host writes: it sends a 15-bit frame that carries a register address and an 11-bit value. When the select then drops low, the value is stored in one of eight control registers that the host can write but not read. These registers drive the rest of the chip through a flat output bus.

When the select is low the host reads. It clocks a 16-bit shift register out of the block, most significant bit first. That shift register holds a snapshot of either a status word or a counter value. The host takes the snapshot by writing a high-to-low step into flag bits of one control register. A selector field in another control register decides whether the shift register drives the data line at all.

All three bus wires come into the system clock domain through two-flop synchronizers, and every register resets to zero.

Top module: `tri_wire_regif`

## Requirements
- R1: While the read/write line is high, the block never drives the data line. Serial clock edges in this mode change only the incoming frame and leave the read shift register untouched.
- R2: Write bits are sampled on rising serial clock edges, least significant bit first. In the 15-bit frame, bits 14..11 are the address and bits 10..0 are the value.
- R3: On a high-to-low step of the read/write line, the frame value is stored in the control register chosen by the address. Register n appears on `ctl_regs[n*11 +: 11]`. No other register changes, and registers change at no other time.
- R4: A frame whose address is 8 to 15 changes no register.
- R5: When more than 15 serial clock edges occur in one write, the last 15 bits received form the frame.
- R6: After reset, every control register and the read shift register are zero, and the data line is not driven.
- R7: The data line is driven only while the read/write line is low and bits 10..7 of register 2 equal 4'b1011. Otherwise the line is released.
- R8: A committed write to register 4 can make several of its flag bits step from 1 to 0. Bit 10 stepping loads `count_i` into the read shift register. Bit 9 stepping loads `status_i`. Bit 4 stepping clears the register. When more than one of these steps happens in the same write, the counter load wins over the status load, and the status load wins over the clear.
- R9: In read mode, the shift register's most significant bit is on the data line before the first serial clock edge. Each rising edge moves the next bit onto the line. After 16 edges, zeros follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sio_rw | input | 1 | Read/write select (high = host writes) |
| sio_clk | input | 1 | Serial clock from the host |
| sio_data | inout | 1 | Bidirectional serial data |
| status_i | input | 16 | Status word captured on request |
| count_i | input | 16 | Counter value captured on request |
| ctl_regs | output | 88 | Eight 11-bit control registers, register n at bits n*11 and up |

## Verification
Each input change reaches the synchronized state after two system clocks, and its effect lands on the next clock. A wrong frame bit, a misdecoded address or a lost commit therefore shows up on `ctl_regs` by the third system clock after the read/write line falls. A wrong snapshot or a shift that is off by one appears on the data line as soon as the host samples the first bit, or at the first rising serial clock edge. A drive-enable fault shows as the data line being held low instead of pulled high, within two clocks of the read/write line changing. The bench runs a reference model that applies the same two-clock input delay and compares the registers and the data line on every clock.

// File: rtl/tri_wire_regif.sv
module tri_wire_regif #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 11,
  parameter int RD_W     = 16,
  parameter int NREG     = 8,
  parameter int SYNC     = 2,
  parameter int SEL_REG  = 2,
  parameter int SEL_LO   = 7,
  parameter int SEL_W    = 4,
  parameter int SEL_PISO = 11,
  parameter int CTL_REG  = 4,
  parameter int LD_CNT   = 10,
  parameter int LD_STS   = 9,
  parameter int CLR_BIT  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sio_rw,
  input  logic                   sio_clk,
  inout  wire                    sio_data,
  input  logic [RD_W-1:0]        status_i,
  input  logic [RD_W-1:0]        count_i,
  output logic [NREG*DATA_W-1:0] ctl_regs
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int IDX_W   = $clog2(NREG);

  logic [SYNC:0][2:0] sy;
  logic [FRAME_W-1:0] frame;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [RD_W-1:0] piso;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else begin
      sy[0] <= {sio_clk, sio_rw, sio_data};
      for (int i = 1; i <= SYNC; i++) sy[i] <= sy[i-1];
    end

  wire clk_now  = sy[SYNC-1][2];
  wire clk_prev = sy[SYNC][2];
  wire rw_now   = sy[SYNC-1][1];
  wire rw_prev  = sy[SYNC][1];
  wire din      = sy[SYNC-1][0];

  wire clk_rise = clk_now & ~clk_prev;
  wire wr_shift = clk_rise & rw_now;
  wire rd_shift = clk_rise & ~rw_now;
  wire commit   = rw_prev & ~rw_now;

  wire [ADDR_W-1:0] fr_addr = frame[FRAME_W-1 -: ADDR_W];
  wire [DATA_W-1:0] fr_data = frame[DATA_W-1:0];
  wire [IDX_W-1:0]  widx    = fr_addr[IDX_W-1:0];
  wire              hit     = int'(fr_addr) < NREG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame <= '0;
    else if (wr_shift) frame <= {din, frame[FRAME_W-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) regs <= '0;
    else if (commit && hit) regs[widx] <= fr_data;

  wire [DATA_W-1:0] ctl = regs[CTL_REG];
  wire ctl_wr = commit && hit && (widx == IDX_W'(CTL_REG));
  wire ld_cnt = ctl_wr && ctl[LD_CNT]  && !fr_data[LD_CNT];
  wire ld_sts = ctl_wr && ctl[LD_STS]  && !fr_data[LD_STS];
  wire ld_clr = ctl_wr && ctl[CLR_BIT] && !fr_data[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        piso <= '0;
    else if (ld_cnt)   piso <= count_i;
    else if (ld_sts)   piso <= status_i;
    else if (ld_clr)   piso <= '0;
    else if (rd_shift) piso <= {piso[RD_W-2:0], 1'b0};

  wire [DATA_W-1:0] selr = regs[SEL_REG];
  wire oe = !rw_now && (selr[SEL_LO +: SEL_W] == SEL_W'(SEL_PISO));

  assign sio_data = oe ? piso[RD_W-1] : 1'bz;
  assign ctl_regs = regs;
endmodule

// File: rtl/tri_wire_regif_chk.sv
module tri_wire_regif_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 11,
  parameter int RD_W   = 16,
  parameter int NREG   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rw_now,
  input logic                   oe,
  input logic                   commit,
  input logic                   hit,
  input logic                   rd_shift,
  input logic                   ld_cnt,
  input logic [RD_W-1:0]        piso,
  input logic [RD_W-1:0]        count_i,
  input logic [NREG*DATA_W-1:0] ctl_regs
);
  AST_QUIET_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rw_now |-> !oe); // R1
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctl_regs)); // R3
  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !hit) |=> $stable(ctl_regs)); // R4
  AST_COUNT_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> piso == $past(count_i)); // R8
  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_shift && !commit) |=> piso == {$past(piso[RD_W-2:0]), 1'b0}); // R9
endmodule

bind tri_wire_regif tri_wire_regif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W), .NREG(NREG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rw_now(rw_now), .oe(oe), .commit(commit),
  .hit(hit), .rd_shift(rd_shift), .ld_cnt(ld_cnt), .piso(piso),
  .count_i(count_i), .ctl_regs(ctl_regs)
);

// File: tb/tri_wire_regif_tb_top.sv
module tri_wire_regif_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic b_clk = 1'b0, b_rw = 1'b0, b_d = 1'b0, h_en = 1'b0;
  wire  sio_data;
  logic [15:0] status_i = 16'hB39C;
  logic [15:0] count_i  = 16'h5E01;
  logic [87:0] ctl_regs;

  assign sio_data = h_en ? b_d : 1'bz;
  pullup (sio_data);

  tri_wire_regif dut_i (
    .clk(clk), .rst_n(rst_n), .sio_rw(b_rw), .sio_clk(b_clk),
    .sio_data(sio_data), .status_i(status_i), .count_i(count_i),
    .ctl_regs(ctl_regs)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: inputs seen two clocks late
  logic [2:0]  h [4];
  logic [10:0] mreg [8];
  logic [14:0] mfr;
  logic [15:0] mpiso;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) h[i] = '0;
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      mfr = '0; mpiso = '0;
    end else begin
      h[3] = h[2]; h[2] = h[1]; h[1] = h[0];
      h[0] = {b_clk, b_rw, sio_data};
      if (h[2][2] && !h[3][2]) begin
        if (h[2][1]) mfr = {h[2][0], mfr[14:1]};
        else mpiso = mpiso << 1;
      end
      if (!h[2][1] && h[3][1] && mfr[14:11] < 8) begin
        automatic int a = int'(mfr[14:11]);
        automatic logic [10:0] old = mreg[a];
        automatic logic [10:0] nw = mfr[10:0];
        mreg[a] = nw;
        if (a == 4) begin
          if (old[10] && !nw[10]) mpiso = count_i;
          else if (old[9] && !nw[9]) mpiso = status_i;
          else if (old[4] && !nw[4]) mpiso = '0;
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int i = 0; i < 8; i++) chk("R3 model reg", 32'(ctl_regs[i*11 +: 11]), 32'(mreg[i]));
      if (!h_en) chk("R7 model line", 32'(sio_data),
                     32'((!h[1][1] && mreg[2][10:7] == 4'd11) ? mpiso[15] : 1'b1));
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) begin
      b_d = v[i]; idle(4); b_clk = 1'b1; idle(4); b_clk = 1'b0;
    end
  endtask

  task automatic wr_pre(logic [31:0] pre, int npre, logic [3:0] a, logic [10:0] d);
    idle(1); b_rw = 1'b1; idle(3); h_en = 1'b1;
    send_bits(pre, npre);
    send_bits({17'd0, a, d}, 15);
    idle(2); h_en = 1'b0; idle(2); b_rw = 1'b0; idle(6);
  endtask

  task automatic wr(logic [3:0] a, logic [10:0] d); wr_pre(0, 0, a, d); endtask

  task automatic rd(output logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      v[i] = sio_data;
      b_clk = 1'b1; idle(6); b_clk = 1'b0; idle(4);
    end
  endtask

  function automatic logic [10:0] rg(int n); return ctl_regs[n*11 +: 11]; endfunction

  initial begin
    logic [15:0] v;
    logic [87:0] snap;
    idle(3); rst_n = 1'b1; idle(4);
    chk("R6 regs after reset", 32'(ctl_regs == '0), 1);
    chk("R6 line released", 32'(sio_data), 1);

    wr(4'd5, 11'h2A5);
    chk("R2 reg5 value", 32'(rg(5)), 32'h2A5);
    chk("R3 only reg5 set", 32'(ctl_regs == (88'h2A5 << 55)), 1);
    wr(4'd0, 11'h7FF);
    chk("R3 reg0 value", 32'(rg(0)), 32'h7FF);
    snap = ctl_regs;
    wr(4'hC, 11'h123);
    chk("R4 addr 12 ignored", 32'(ctl_regs == snap), 1);
    wr(4'hF, 11'h7FF);
    chk("R4 addr 15 ignored", 32'(ctl_regs == snap), 1);
    wr_pre(32'h7, 3, 4'd3, 11'h0F0);
    chk("R5 extra leading bits", 32'(rg(3)), 32'h0F0);

    wr(4'd4, 11'h400); wr(4'd4, 11'h000);
    chk("R7 not selected releases line", 32'(sio_data), 1);
    wr(4'd2, 11'h580);
    chk("R7 selected drives count MSB", 32'(sio_data), 0);
    rd(v);
    chk("R9 count read MSB first", 32'(v), 32'h5E01);
    chk("R9 zero fill after 16", 32'(sio_data), 0);

    wr(4'd4, 11'h610); wr(4'd4, 11'h000);
    rd(v);
    chk("R8 count beats status and clear", 32'(v), 32'h5E01);
    wr(4'd4, 11'h210); wr(4'd4, 11'h000);
    wr(4'd1, 11'h055);
    rd(v);
    chk("R8 status beats clear", 32'(v), 32'hB39C);
    chk("R1 write clocks left snapshot", 32'(rg(1)), 32'h055);
    wr(4'd4, 11'h200); wr(4'd4, 11'h010); wr(4'd4, 11'h000);
    chk("R8 clear empties register", 32'(sio_data), 0);
    rd(v);
    chk("R8 cleared read", 32'(v), 32'h0000);
    wr(4'd4, 11'h200); wr(4'd4, 11'h000);
    wr(4'd2, 11'h000);
    chk("R7 deselect releases line", 32'(sio_data), 1);
    wr(4'd2, 11'h580);
    chk("R9 first bit before clock", 32'(sio_data), 1);

    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R3 got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule